// File: doc/BRIEF.md
# Video Capture Window Cropper and Decimating Scaler

This block sits behind the sync-polarity stage of a video capture path. It runs on the pixel clock. It locates each incoming pixel relative to the syncs: the column is counted from the end of the horizontal sync pulse, and the line is counted from the end of the vertical sync pulse, less a programmable start-adjust line count. The block compares that position with a programmable rectangle. It can then keep the pixels inside the rectangle or the pixels outside it. Next it thins the surviving pixels and lines by an N-of-64 ratio, and it issues a write strobe with a linear buffer address for every pixel it keeps.

In the buffer, each captured line takes a fixed 1024-byte slot. The X offset is the number of pixels already written in the current line. The Y slot is the number of lines already written in the current frame. Each of the two offsets can either wrap at its maximum or hold there. The output is a single-cycle strobe with no back-pressure, because a live video source cannot be stalled. The memory side must therefore accept a write in any cycle in which `wr_valid` is high. The address is valid only in those cycles.

Top module: `cwin_capture`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `wr_valid` is low.
- R2: The column of a pixel is the number of pixel cycles since `hsync` went low, counted from 0. The column counter holds at 1023. With cropping on and inside mode selected, column x passes if `cfg_x_start <= x < cfg_x_end`.
- R3: The raw line is the number of `hsync` rising edges seen while `vsync` is low, counted since `vsync` fell. The line index is y = raw − `cfg_v_adjust`. A line whose raw value is below the adjust count is never written. With cropping on and inside mode selected, a line passes if `cfg_y_start <= y < cfg_y_end`. No write is issued for a pixel presented while `hsync` or `vsync` is high.
- R4: With `cfg_crop_en`=1 and `cfg_crop_outside`=1, the block writes exactly the active pixels that fail the rectangle test.
- R5: With `cfg_crop_en`=0, every active pixel is written when no scaling is enabled, and `cfg_crop_outside` has no effect.
- R6: With `cfg_hscale_en`=1 and ratio N, the k-th pixel of a line that passes cropping (k from 0) is kept if floor((k+1)·N/64) > floor(k·N/64). The count k restarts on every line.
- R7: With `cfg_vscale_en`=1 and ratio N, active line y is kept if floor((y+1)·N/64) > floor(y·N/64). Every active line advances this count, whether or not it has any pixels in the rectangle.
- R8: `wr_addr` = (`cfg_base` + 1024·Y + X) mod 2^20. X is the number of writes earlier in the same line. Y is the number of earlier lines in the frame that had at least one write.
- R9: When X reaches 1023, the next write in the same line uses X=0 if `cfg_x_hold`=0, and X=1023 if `cfg_x_hold`=1.
- R10: When Y reaches 1023, the next written line uses Y=0 if `cfg_y_hold`=0, and Y=1023 if `cfg_y_hold`=1.
- R11: A pixel presented while `cap_en` is low is never written.
- R12: The strobe and the address appear in the cycle after the pixel clock edge at which the pixel was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync, active high, polarity already corrected |
| vsync | input | 1 | Vertical sync, active high, polarity already corrected |
| cap_en | input | 1 | Capture enable |
| cfg_crop_en | input | 1 | Rectangle test enable |
| cfg_crop_outside | input | 1 | 1: keep pixels outside the rectangle; 0: keep pixels inside it |
| cfg_x_start | input | 10 | First column inside the rectangle |
| cfg_x_end | input | 10 | First column past the rectangle |
| cfg_y_start | input | 10 | First line inside the rectangle |
| cfg_y_end | input | 10 | First line past the rectangle |
| cfg_v_adjust | input | 6 | Lines from the end of vsync to the first active line (non-zero) |
| cfg_hscale_en | input | 1 | Horizontal decimation enable |
| cfg_hscale_n | input | 6 | Pixels kept per 64 (1..63) |
| cfg_vscale_en | input | 1 | Vertical decimation enable |
| cfg_vscale_n | input | 6 | Lines kept per 64 (1..63) |
| cfg_base | input | 20 | Buffer start address |
| cfg_x_hold | input | 1 | X offset holds at its maximum instead of wrapping |
| cfg_y_hold | input | 1 | Y slot holds at its maximum instead of wrapping |
| wr_valid | output | 1 | Write strobe, one cycle per kept pixel |
| wr_addr | output | 20 | Buffer address of the kept pixel |

## Verification
Cropping and horizontal decimation can act on the same pixel. The decimation accumulator advances only on pixels that pass the rectangle test, so the first kept pixel of a line is set by the window edge and the ratio together. A combined scenario provokes this. It programs a window that starts mid-line and enables both scalers. The bench then checks each strobe against the kept positions that it computes from the floor formulas, counting from the window edge. The end of a line can also carry two updates at once: the Y slot advance and the vertical decimator step. The same scenario's line-by-line address sequence judges this case.

// File: rtl/cwin_pkg.sv
package cwin_pkg;
  localparam int CNT_W       = 10;
  localparam int ADJ_W       = 6;
  localparam int RATIO_W     = 6;
  localparam int STRIDE_LOG2 = 10;
  localparam int ADDR_W      = 20;

  // inclusive start, exclusive end
  function automatic logic span_hit(input logic [CNT_W:0] pos,
                                    input logic [CNT_W:0] lo,
                                    input logic [CNT_W:0] hi);
    return (pos >= lo) && (pos < hi);
  endfunction
endpackage

// File: rtl/cwin_sync_cnt.sv
module cwin_sync_cnt #(
  parameter int CNT_W = 10,
  parameter int ADJ_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic             vsync,
  input  logic [ADJ_W-1:0] adj,
  output logic [CNT_W-1:0] x_pos,
  output logic [CNT_W:0]   y_pos,
  output logic             line_act,
  output logic             pix_slot,
  output logic             line_end
);
  localparam logic [CNT_W-1:0] X_MAX = '1;
  localparam logic [CNT_W:0]   L_MAX = '1;

  logic           hs_q;
  logic [CNT_W:0] raw_line;
  logic [CNT_W:0] adj_ext;

  assign adj_ext  = (CNT_W + 1)'(adj);
  assign line_end = hsync && !hs_q && !vsync;
  assign pix_slot = !hsync && !vsync;
  assign line_act = raw_line >= adj_ext;
  assign y_pos    = raw_line - adj_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q     <= 1'b0;
      x_pos    <= '0;
      raw_line <= '0;
    end else begin
      hs_q <= hsync;
      if (hsync) x_pos <= '0;
      else if (x_pos != X_MAX) x_pos <= x_pos + 1'b1;
      if (vsync) raw_line <= '0;
      else if (line_end && raw_line != L_MAX) raw_line <= raw_line + 1'b1;
    end
  end
endmodule

// File: rtl/cwin_decim.sv
module cwin_decim #(
  parameter int RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  input  logic               enable,
  input  logic [RATIO_W-1:0] ratio,
  output logic               keep
);
  logic [RATIO_W-1:0] acc;
  logic [RATIO_W:0]   sum;

  assign sum  = {1'b0, acc} + {1'b0, ratio};
  assign keep = !enable || sum[RATIO_W];

  always_ff @(posedge clk) begin
    if (!rst_n)                acc <= '0;
    else if (clr)              acc <= '0;
    else if (step && enable)   acc <= sum[RATIO_W-1:0];
  end
endmodule

// File: rtl/cwin_addr.sv
module cwin_addr #(
  parameter int STRIDE_LOG2 = 10,
  parameter int ADDR_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_clr,
  input  logic              frame_clr,
  input  logic              line_end,
  input  logic              wr,
  input  logic              x_hold,
  input  logic              y_hold,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr
);
  localparam int Y_W = ADDR_W - STRIDE_LOG2;
  localparam logic [STRIDE_LOG2-1:0] X_MAX = '1;
  localparam logic [Y_W-1:0]         Y_MAX = '1;

  logic [STRIDE_LOG2-1:0] xi;
  logic [Y_W-1:0]         yi;
  logic                   wrote;

  assign addr = base + {yi, xi};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xi    <= '0;
      yi    <= '0;
      wrote <= 1'b0;
    end else begin
      if (line_clr) begin
        xi    <= '0;
        wrote <= 1'b0;
      end else if (wr) begin
        wrote <= 1'b1;
        if (xi != X_MAX) xi <= xi + 1'b1;
        else if (!x_hold) xi <= '0;
      end
      if (frame_clr) yi <= '0;
      else if (line_end && wrote) begin
        if (yi != Y_MAX) yi <= yi + 1'b1;
        else if (!y_hold) yi <= '0;
      end
    end
  end
endmodule

// File: rtl/cwin_capture.sv
module cwin_capture
  import cwin_pkg::*;
#(
  parameter int P_CNT_W   = CNT_W,
  parameter int P_ADJ_W   = ADJ_W,
  parameter int P_RATIO_W = RATIO_W,
  parameter int P_STRIDE  = STRIDE_LOG2,
  parameter int P_ADDR_W  = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hsync,
  input  logic                 vsync,
  input  logic                 cap_en,
  input  logic                 cfg_crop_en,
  input  logic                 cfg_crop_outside,
  input  logic [P_CNT_W-1:0]   cfg_x_start,
  input  logic [P_CNT_W-1:0]   cfg_x_end,
  input  logic [P_CNT_W-1:0]   cfg_y_start,
  input  logic [P_CNT_W-1:0]   cfg_y_end,
  input  logic [P_ADJ_W-1:0]   cfg_v_adjust,
  input  logic                 cfg_hscale_en,
  input  logic [P_RATIO_W-1:0] cfg_hscale_n,
  input  logic                 cfg_vscale_en,
  input  logic [P_RATIO_W-1:0] cfg_vscale_n,
  input  logic [P_ADDR_W-1:0]  cfg_base,
  input  logic                 cfg_x_hold,
  input  logic                 cfg_y_hold,
  output logic                 wr_valid,
  output logic [P_ADDR_W-1:0]  wr_addr
);
  logic [P_CNT_W-1:0] x_pos;
  logic [P_CNT_W:0]   y_pos;
  logic line_act, pix_slot, line_end;
  logic hit_x, hit_y, region, cand, hkeep, vkeep, write;
  logic [P_ADDR_W-1:0] addr_now;

  cwin_sync_cnt #(.CNT_W(P_CNT_W), .ADJ_W(P_ADJ_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .adj(cfg_v_adjust), .x_pos(x_pos), .y_pos(y_pos),
    .line_act(line_act), .pix_slot(pix_slot), .line_end(line_end)
  );

  assign hit_x  = span_hit({1'b0, x_pos}, {1'b0, cfg_x_start}, {1'b0, cfg_x_end});
  assign hit_y  = span_hit(y_pos, {1'b0, cfg_y_start}, {1'b0, cfg_y_end});
  assign region = !cfg_crop_en || ((hit_x && hit_y) ^ cfg_crop_outside);
  assign cand   = cap_en && pix_slot && line_act && region && vkeep;
  assign write  = cand && hkeep;

  cwin_decim #(.RATIO_W(P_RATIO_W)) u_hdec (
    .clk(clk), .rst_n(rst_n), .clr(hsync), .step(cand),
    .enable(cfg_hscale_en), .ratio(cfg_hscale_n), .keep(hkeep)
  );

  cwin_decim #(.RATIO_W(P_RATIO_W)) u_vdec (
    .clk(clk), .rst_n(rst_n), .clr(vsync), .step(line_end && line_act),
    .enable(cfg_vscale_en), .ratio(cfg_vscale_n), .keep(vkeep)
  );

  cwin_addr #(.STRIDE_LOG2(P_STRIDE), .ADDR_W(P_ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .line_clr(hsync), .frame_clr(vsync),
    .line_end(line_end), .wr(write), .x_hold(cfg_x_hold),
    .y_hold(cfg_y_hold), .base(cfg_base), .addr(addr_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
    end else begin
      wr_valid <= write;
      if (write) wr_addr <= addr_now;
    end
  end
endmodule

// File: rtl/cwin_capture_chk.sv
module cwin_capture_chk #(
  parameter int P_ADDR_W = 20,
  parameter int P_STRIDE = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hsync,
  input logic                vsync,
  input logic                cap_en,
  input logic                cfg_x_hold,
  input logic [P_ADDR_W-1:0] cfg_base,
  input logic                wr_valid,
  input logic [P_ADDR_W-1:0] wr_addr
);
  localparam logic [P_STRIDE-1:0] XM = '1;
  logic [P_ADDR_W-1:0] base_q;
  logic [P_ADDR_W-1:0] off;
  logic [P_STRIDE-1:0] xoff;
  logic [P_ADDR_W-P_STRIDE-1:0] yoff;

  always_ff @(posedge clk) base_q <= cfg_base;
  assign off  = wr_addr - base_q;
  assign xoff = off[P_STRIDE-1:0];
  assign yoff = off[P_ADDR_W-1:P_STRIDE];

  // R11
  capoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> !wr_valid);

  // R3
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync || vsync) |=> !wr_valid);

  // R8
  xstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid) && $stable(base_q) && $past(xoff) != XM)
      |-> (xoff == $past(xoff) + 1'b1) && (yoff == $past(yoff)));

  // R9
  xhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid) && $stable(base_q) && $past(xoff) == XM
      && $past(cfg_x_hold)) |-> xoff == XM);

  // R9
  xwrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid) && $stable(base_q) && $past(xoff) == XM
      && !$past(cfg_x_hold)) |-> xoff == '0);
endmodule

bind cwin_capture cwin_capture_chk #(.P_ADDR_W(P_ADDR_W), .P_STRIDE(P_STRIDE)) chk_i (.*);

// File: tb/cwin_capture_tb_top.sv
`timescale 1ns/1ps
module cwin_capture_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b1, vsync = 1'b1, cap_en = 1'b0;
  logic c_crop_en = 1'b0, c_out = 1'b0;
  logic [9:0] c_xs = '0, c_xe = '0, c_ys = '0, c_ye = '0;
  logic [5:0] c_adj = 6'd1, c_hn = 6'd1, c_vn = 6'd1;
  logic c_hs_en = 1'b0, c_vs_en = 1'b0, c_xh = 1'b0, c_yh = 1'b0;
  logic [19:0] c_base = '0;
  logic wr_valid;
  logic [19:0] wr_addr;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  cwin_capture dut_i (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .cap_en(cap_en),
    .cfg_crop_en(c_crop_en), .cfg_crop_outside(c_out),
    .cfg_x_start(c_xs), .cfg_x_end(c_xe), .cfg_y_start(c_ys), .cfg_y_end(c_ye),
    .cfg_v_adjust(c_adj), .cfg_hscale_en(c_hs_en), .cfg_hscale_n(c_hn),
    .cfg_vscale_en(c_vs_en), .cfg_vscale_n(c_vn), .cfg_base(c_base),
    .cfg_x_hold(c_xh), .cfg_y_hold(c_yh), .wr_valid(wr_valid), .wr_addr(wr_addr)
  );

  task automatic chk(input logic ok, input string tag, input logic [20:0] act, input logic [20:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // applies one frame and checks each output cycle (R12: one cycle later)
  task automatic run_frame(input int nl, input int len, input string tag);
    int yi = 0;
    hsync = 1'b1; vsync = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(!wr_valid, {tag, " vsync"}, {20'd0, wr_valid}, 21'd0);
    end
    for (int r = 0; r < nl; r++) begin
      bit act = r >= int'(c_adj);
      int y = r - int'(c_adj);
      bit vk = act && (!c_vs_en || (((y + 1) * int'(c_vn)) / 64 != (y * int'(c_vn)) / 64));
      int k = 0, xi = 0;
      bit wrote = 0;
      for (int x = 0; x < len; x++) begin
        int xx = (x > 1023) ? 1023 : x;
        bit inw = xx >= int'(c_xs) && xx < int'(c_xe) && y >= int'(c_ys) && y < int'(c_ye);
        bit rg = !c_crop_en || (inw ^ c_out);
        bit cand = cap_en && act && rg && vk;
        bit hk = cand && (!c_hs_en || (((k + 1) * int'(c_hn)) / 64 != (k * int'(c_hn)) / 64));
        logic [19:0] ea = 20'(int'(c_base) + yi * 1024 + xi);
        hsync = 1'b0; vsync = 1'b0;
        step();
        if (wr_valid !== hk)
          chk(1'b0, {tag, " strobe"}, {20'd0, wr_valid}, {20'd0, hk});
        else if (hk)
          chk(wr_addr === ea, {tag, " addr"}, {1'b0, wr_addr}, {1'b0, ea});
        else
          chk(1'b1, tag, 21'd0, 21'd0);
        if (cand) k++;
        if (hk) begin
          wrote = 1;
          if (xi != 1023) xi++;
          else if (!c_xh) xi = 0;
        end
      end
      if (wrote) begin
        if (yi != 1023) yi++;
        else if (!c_yh) yi = 0;
      end
      hsync = 1'b1;
      for (int i = 0; i < 2; i++) begin
        step();
        chk(!wr_valid, {tag, " hsync"}, {20'd0, wr_valid}, 21'd0);
      end
    end
  endtask

  task automatic defaults();
    cap_en = 1'b1; c_crop_en = 0; c_out = 0; c_hs_en = 0; c_vs_en = 0;
    c_xh = 0; c_yh = 0; c_adj = 6'd1; c_base = 20'h01000;
  endtask

  task automatic t_reset();
    repeat (3) begin
      step();
      chk(!wr_valid, "R1 in reset", {20'd0, wr_valid}, 21'd0);
    end
    rst_n = 1'b1;
    step();
    chk(!wr_valid, "R1 after reset", {20'd0, wr_valid}, 21'd0);
  endtask

  task automatic t_crop_in();
    defaults(); c_crop_en = 1; c_xs = 10'd3; c_xe = 10'd7; c_ys = 10'd1; c_ye = 10'd3; c_adj = 6'd2;
    run_frame(7, 10, "R2 R3 R8 R12 inside");
  endtask

  task automatic t_crop_out();
    defaults(); c_crop_en = 1; c_out = 1; c_xs = 10'd2; c_xe = 10'd5; c_ys = 10'd0; c_ye = 10'd2; c_adj = 6'd1;
    c_base = 20'h3A5C0;
    run_frame(5, 8, "R4 outside");
  endtask

  task automatic t_nocrop();
    defaults(); c_out = 1; c_adj = 6'd3;
    run_frame(6, 9, "R5 no crop");
  endtask

  task automatic t_hscale();
    defaults(); c_hs_en = 1; c_hn = 6'd24;
    run_frame(3, 40, "R6 n=24");
    c_hn = 6'd63;
    run_frame(3, 70, "R6 n=63");
  endtask

  task automatic t_vscale();
    defaults(); c_vs_en = 1; c_vn = 6'd20;
    run_frame(14, 3, "R7 n=20");
  endtask

  task automatic t_both();
    defaults(); c_crop_en = 1; c_xs = 10'd5; c_xe = 10'd25; c_ys = 10'd2; c_ye = 10'd9;
    c_hs_en = 1; c_hn = 6'd32; c_vs_en = 1; c_vn = 6'd40;
    run_frame(12, 30, "R2 R6 R7 combined");
  endtask

  task automatic t_xwrap();
    defaults(); c_xh = 0;
    run_frame(2, 1030, "R9 x wrap");
    c_xh = 1;
    run_frame(2, 1030, "R9 x hold");
  endtask

  task automatic t_ywrap();
    defaults(); c_base = 20'hFFC00; c_yh = 0;
    run_frame(1028, 1, "R10 R8 y wrap");
    c_yh = 1;
    run_frame(1028, 1, "R10 y hold");
  endtask

  task automatic t_capoff();
    defaults(); cap_en = 1'b0;
    run_frame(4, 6, "R11 capture off");
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_crop_in();
    t_crop_out();
    t_nocrop();
    t_hscale();
    t_vscale();
    t_both();
    t_xwrap();
    t_ywrap();
    t_capoff();
    summary();
    $finish;
  end
endmodule